// File: doc/BRIEF.md
# SPI Command Sequencer

This block is a small SPI master that runs a program instead of waiting for register pokes. A host places 16-bit instruction words on a command stream. The sequencer takes them one at a time and acts on each in turn. It can move bytes over the serial bus, change the eight active-low selects and wait afterwards, retune its own clock divider and bus mode partway through a program, pause for a number of serial clock periods, and post a sync token back to the host once everything before it has finished.

Outgoing bytes arrive on a valid/ready transmit stream. Incoming bytes leave through a valid/ready receive stream that holds one byte. Either stream can hold the bus still: while a byte is blocked, the serial clock stops between bytes. The host is normally fed by three FIFOs, one each for commands, transmit data and receive data. A program usually sets the mode and divider, asserts a select, transfers bytes, releases the select, and ends with a sync token.

Top module: `spi_seq_core`

## Requirements
- R1: An instruction word has its opcode in bits 15:12, argument A in bits 11:8 and argument B in bits 7:0. Instructions are accepted one at a time, in arrival order. `cmd_ready` is high only when no earlier instruction is still running.
- R2: After reset, `cs_n` is 8'hFF, `sclk` and `mosi` are 0, `sdo_oe` is 1, `cmd_ready` is 1, and `rx_valid` and `sync_valid` are 0. The divider and mode are both zero.
- R3: Opcode 0 moves B+1 bytes (1 to 256). Each byte makes exactly 16 `sclk` edges. When A bit 0 is set, each byte comes from the transmit stream and is shifted out MSB first on `mosi`.
- R4: When A bit 1 of opcode 0 is set, each received byte is assembled MSB first and offered on `rx_data` with `rx_valid`. When A bit 1 is clear, no byte is offered.
- R5: When A bit 0 of opcode 0 is clear, `mosi` is 0 at every sampling edge and no transmit byte is taken (`tx_ready` stays low).
- R6: Opcode 2 with A=1 loads the mode: B bit 0 is clock phase, B bit 1 is clock polarity, B bit 2 is three-wire. `sclk` idles at the polarity level. With phase 0, data is sampled on the leading edge of each bit. With phase 1, data is sampled on the trailing edge.
- R7: Opcode 2 with A=0 loads the divider D from B. Within a byte, successive `sclk` edges are D+1 clock cycles apart.
- R8: Opcode 1 drives B onto `cs_n`. The next instruction is then held off for 2·A·(D+1) cycles; with A=0 there is no hold-off.
- R9: Opcode 3 with A=1 is a pause of B+1 serial clock periods. It holds off the next instruction for 2·(B+1)·(D+1) cycles and does not toggle `sclk`.
- R10: Opcode 3 with A=0 raises `sync_valid` for one cycle with `sync_id`=B. This happens only after every earlier instruction has finished, including delivery of its last received byte.
- R11: Before a byte starts, if it needs a transmit byte and `tx_valid` is low, or needs receive space and `rx_valid` is still pending, the byte waits and `sclk` does not toggle.
- R12: `sdo_oe` is always 1 when three-wire is off. When three-wire is on, it is 1 only while a transfer with A bit 0 set is running.
- R13: Opcodes 4 to 15, opcode 2 with A above 1, and opcode 3 with A above 1 change no output and no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Instruction word available |
| cmd_ready | output | 1 | Sequencer takes the word this cycle |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| tx_data | input | DW | Transmit byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Receiver takes the pending byte |
| rx_data | output | DW | Received byte |
| sync_valid | output | 1 | One-cycle sync token |
| sync_id | output | 8 | Identifier carried by the sync token |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low selects |

## Verification
The bench acts as a serial slave in all four polarity/phase combinations and in the three-wire setting. Swapping the sample edge would corrupt every captured byte, and a wrong edge count or wrong edge spacing is caught at the offending edge. It targets the 256-byte count encoding, a read-only transfer that must keep `mosi` low and leave the transmit stream untouched, and stalls on both an empty transmit stream and a receive byte that has not been taken; a design that toggled through a stall would show extra edges during the hold. Pause and select hold-off lengths are measured in cycles against the divider, so an off-by-one period shows up. The bench also checks that unused opcodes leave the selects, the sync count and the divider alone.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int INSN_W = 16;

  // opcode values (bits 15:12 of an instruction)
  localparam logic [3:0] OP_SHIFT  = 4'h0;
  localparam logic [3:0] OP_SEL    = 4'h1;
  localparam logic [3:0] OP_SETREG = 4'h2;
  localparam logic [3:0] OP_MISC   = 4'h3;

  // argument A sub-codes
  localparam logic [3:0] REG_DIV    = 4'h0;
  localparam logic [3:0] REG_MODE   = 4'h1;
  localparam logic [3:0] MISC_SYNC  = 4'h0;
  localparam logic [3:0] MISC_PAUSE = 4'h1;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a;
    logic [7:0] b;
  } insn_t;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_LOAD,
    ST_BITS,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/spi_seq_tick.sv
// Half-period tick generator: one tick every (div+1) cycles while run is high.
module spi_seq_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_seq_shift.sv
// Byte shifter: serial clock, MSB-first data out and data in for both phases.
module spi_seq_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          cpha,
  input  logic          tick,
  input  logic          miso,
  input  logic          set_idle,
  input  logic          idle_lvl,
  output logic          sclk,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE);

  logic [EW-1:0] edge_n;
  logic [DW-1:0] tsr;
  logic [DW-1:0] rsr;
  logic          lead;
  logic          last;
  logic          sample;
  logic          shift;

  assign lead    = ~edge_n[0];
  assign last    = (edge_n == EW'(NEDGE - 1));
  assign sample  = tick && (lead ^ cpha);
  assign shift   = tick && !(lead ^ cpha) && !(!cpha && last);
  assign done    = tick && last;
  assign rx_byte = cpha ? {rsr[DW-2:0], miso} : rsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      edge_n <= '0;
      tsr    <= '0;
      rsr    <= '0;
    end else begin
      if (set_idle)  sclk <= idle_lvl;
      else if (tick) sclk <= ~sclk;

      if (load) begin
        edge_n <= '0;
        if (!cpha) begin
          mosi <= load_byte[DW-1];
          tsr  <= {load_byte[DW-2:0], 1'b0};
        end else begin
          tsr  <= load_byte;
        end
      end else if (tick) begin
        edge_n <= edge_n + 1'b1;
        if (shift) begin
          mosi <= tsr[DW-1];
          tsr  <= {tsr[DW-2:0], 1'b0};
        end
        if (sample) rsr <= {rsr[DW-2:0], miso};
      end
    end
  end
endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
  import spi_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NCS  = 8,
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [INSN_W-1:0] cmd_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DW-1:0]     tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DW-1:0]     rx_data,
  output logic              sync_valid,
  output logic [7:0]        sync_id,
  output logic              sclk,
  output logic              mosi,
  output logic              sdo_oe,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  localparam int WW = 10;  // holds 2*(255+1) half periods

  seq_st_e         state;
  insn_t           ins;
  logic [DIVW-1:0] div_q;
  logic            cpha_q, cpol_q, tw_q;
  logic            wr_q, rd_q;
  logic [7:0]      bytes_left;
  logic [WW-1:0]   wait_left;
  logic            tick, run, byte_go, done;
  logic            set_idle;
  logic [DW-1:0]   rx_byte;

  assign ins       = insn_t'(cmd_data);
  assign cmd_ready = (state == ST_FETCH);
  assign byte_go   = (state == ST_LOAD) && (!wr_q || tx_valid) && !(rd_q && rx_valid);
  assign tx_ready  = byte_go && wr_q;
  assign run       = (state == ST_BITS) || (state == ST_WAIT);
  assign set_idle  = cmd_valid && cmd_ready && (ins.op == OP_SETREG) && (ins.a == REG_MODE);

  spi_seq_tick #(.DIVW(DIVW)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .div (div_q),
    .tick(tick)
  );

  spi_seq_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (byte_go),
    .load_byte(wr_q ? tx_data : '0),
    .cpha     (cpha_q),
    .tick     (tick && (state == ST_BITS)),
    .miso     (miso),
    .set_idle (set_idle),
    .idle_lvl (ins.b[1]),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (done),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FETCH;
      div_q      <= '0;
      cpha_q     <= 1'b0;
      cpol_q     <= 1'b0;
      tw_q       <= 1'b0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      bytes_left <= '0;
      wait_left  <= '0;
      cs_n       <= '1;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      sync_valid <= 1'b0;
      sync_id    <= '0;
      sdo_oe     <= 1'b1;
    end else begin
      sync_valid <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      unique case (state)
        ST_FETCH: begin
          if (cmd_valid) begin
            case (ins.op)
              OP_SHIFT: begin
                wr_q       <= ins.a[0];
                rd_q       <= ins.a[1];
                bytes_left <= ins.b;
                sdo_oe     <= !tw_q || ins.a[0];
                state      <= ST_LOAD;
              end
              OP_SEL: begin
                cs_n <= ins.b[NCS-1:0];
                if (ins.a != 4'h0) begin
                  wait_left <= WW'({ins.a, 1'b0});
                  state     <= ST_WAIT;
                end
              end
              OP_SETREG: begin
                if (ins.a == REG_DIV) begin
                  div_q <= DIVW'(ins.b);
                end else if (ins.a == REG_MODE) begin
                  cpha_q <= ins.b[0];
                  cpol_q <= ins.b[1];
                  tw_q   <= ins.b[2];
                  sdo_oe <= !ins.b[2];
                end
              end
              OP_MISC: begin
                if (ins.a == MISC_SYNC) begin
                  sync_valid <= 1'b1;
                  sync_id    <= ins.b;
                end else if (ins.a == MISC_PAUSE) begin
                  wait_left <= WW'((32'(ins.b) + 32'd1) * 32'd2);
                  state     <= ST_WAIT;
                end
              end
              default: ;
            endcase
          end
        end
        ST_LOAD: begin
          if (byte_go) state <= ST_BITS;
        end
        ST_BITS: begin
          if (done) begin
            if (rd_q) begin
              rx_data  <= rx_byte;
              rx_valid <= 1'b1;
            end
            if (bytes_left == 8'd0) begin
              state  <= ST_FETCH;
              sdo_oe <= !tw_q;
            end else begin
              bytes_left <= bytes_left - 1'b1;
              state      <= ST_LOAD;
            end
          end
        end
        ST_WAIT: begin
          if (tick) begin
            wait_left <= wait_left - 1'b1;
            if (wait_left == WW'(1)) state <= ST_FETCH;
          end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int DW  = 8,
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [15:0]    cmd_data,
  input logic [NCS-1:0] cs_n,
  input logic           sclk,
  input logic           cpol_q,
  input logic           tw_q,
  input logic           sdo_oe,
  input logic           sync_valid,
  input logic           rx_valid,
  input logic           rx_ready,
  input logic [DW-1:0]  rx_data
);
  // R8: selects move only after a select instruction was taken
  p_cs_only_by_insn_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == 4'h1));

  // R6: between instructions the serial clock rests at the polarity level
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (sclk == cpol_q));

  // R12: output enable stays on outside three-wire operation
  p_oe_fourwire_r12: assert property (@(posedge clk) disable iff (rst)
    !tw_q |-> sdo_oe);

  // R10: a token follows only a taken sync instruction
  p_sync_from_insn_r10: assert property (@(posedge clk) disable iff (rst)
    sync_valid |-> $past(cmd_valid && cmd_ready && cmd_data[15:8] == 8'h30));

  // R11: a pending received byte is held until taken
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_seq_core spi_seq_chk #(.DW(DW), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .cpol_q    (cpol_q),
  .tw_q      (tw_q),
  .sdo_oe    (sdo_oe),
  .sync_valid(sync_valid),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data)
);

// File: tb/sim_spi_seq_core.sv
module sim_spi_seq_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_data = 16'h0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [7:0]  tx_data = 8'h0;
  logic        rx_valid, rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        sync_valid;
  logic [7:0]  sync_id;
  logic        sclk, mosi, sdo_oe, miso;
  logic [7:0]  cs_n;

  spi_seq_core u0 (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id),
    .sclk(sclk), .mosi(mosi), .sdo_oe(sdo_oe), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // instruction builders
  function automatic logic [15:0] f_xfer(input bit wr, input bit rd, input int n);
    return {4'h0, 2'b00, rd, wr, 8'(n - 1)};
  endfunction
  function automatic logic [15:0] f_sel(input logic [3:0] dly, input logic [7:0] m);
    return {4'h1, dly, m};
  endfunction
  function automatic logic [15:0] f_reg(input logic [3:0] a, input logic [7:0] v);
    return {4'h2, a, v};
  endfunction
  function automatic logic [15:0] f_misc(input logic [3:0] a, input logic [7:0] v);
    return {4'h3, a, v};
  endfunction

  // transmit feeder
  logic [7:0] txq [0:1023];
  int tx_n = 0, tx_ptr = 0;
  bit tx_en = 1'b1, tx_pend = 1'b0;
  initial forever begin
    @(negedge clk);
    if (tx_pend) tx_ptr++;
    tx_valid = tx_en && (tx_ptr < tx_n);
    tx_data  = tx_valid ? txq[tx_ptr] : 8'h00;
    #1;
    tx_pend = tx_valid && tx_ready;
  end

  // receive sink
  logic [7:0] rx_got [0:1023];
  int rx_n = 0;
  bit rx_en = 1'b1;
  initial forever begin
    @(negedge clk);
    rx_ready = rx_en;
    #1;
    if (rx_valid && rx_ready) begin
      rx_got[rx_n] = rx_data;
      rx_n++;
    end
  end

  // sync monitor
  int sync_n = 0, rx_at_sync = 0;
  logic [7:0] sync_last = 8'h0;
  initial forever begin
    @(negedge clk);
    #2;
    if (sync_valid) begin
      sync_n++;
      sync_last  = sync_id;
      rx_at_sync = rx_n;
    end
  end

  // serial slave model
  logic [7:0] slq [0:1023];
  logic [7:0] mo_got [0:1023];
  logic [7:0] mo_sh = 8'h0;
  int mo_n = 0, mo_bits = 0, sb = 0, edges = 0, cyc = 0, last_t = 0;
  logic prev_sclk = 1'b0;
  bit cpol_b = 1'b0, cpha_b = 1'b0, tw_b = 1'b0;
  int div_b = 0;
  assign miso = slq[(sb >> 3) % 1024][7 - (sb % 8)];
  initial forever begin
    @(negedge clk);
    cyc++;
    if (!rst && sclk !== prev_sclk && cs_n !== 8'hFF) begin
      if (edges % 16 != 0) chk(cyc - last_t == div_b + 1, "R7 edge spacing", cyc - last_t, div_b + 1);
      last_t = cyc;
      if ((sclk != cpol_b) == (cpha_b == 1'b0)) begin
        mo_sh = {mo_sh[6:0], mosi};
        mo_bits++;
        if (mo_bits == 8) begin
          mo_got[mo_n % 1024] = mo_sh;
          mo_n++;
          mo_bits = 0;
        end
        sb++;
      end
      edges++;
    end
    prev_sclk = sclk;
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send_time(input logic [15:0] w, output int t);
    send(w);
    t = 0;
    @(negedge clk);
    while (!cmd_ready) begin
      t++;
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input bit pol, input bit pha, input bit tw, input int d);
    cpol_b = pol; cpha_b = pha; tw_b = tw; div_b = d;
    send(f_reg(4'h1, {5'b0, tw, pol, pha}));
    send(f_reg(4'h0, 8'(d)));
  endtask

  task automatic wait_sync(input int s0);
    for (int k = 0; k < 100000 && sync_n == s0; k++) @(negedge clk);
  endtask

  // stall: 0 none, 1 transmit empty, 2 receive held
  task automatic run_xfer(input bit wr, input bit rd, input int n, input int csi,
                          input logic [7:0] id, input int stall);
    int s0, r0, m0, e0, t0, tp0, y0;
    logic [7:0] m;
    s0 = sb >> 3; r0 = rx_n; m0 = mo_n; e0 = edges; tp0 = tx_ptr; y0 = sync_n;
    t0 = tx_n;
    if (stall == 1) tx_en = 1'b0;
    if (stall == 2) rx_en = 1'b0;
    if (wr) begin
      for (int i = 0; i < n; i++) txq[t0 + i] = 8'($urandom);
      tx_n = t0 + n;
    end
    m = ~(8'h01 << csi);
    send(f_sel(4'h1, m));
    chk(cs_n == m, "R8 select value", cs_n, m);
    send(f_xfer(wr, rd, n));
    chk(cmd_ready == 1'b0, "R1 busy during transfer", cmd_ready, 0);
    chk(sdo_oe == (!tw_b || wr), "R12 oe during transfer", sdo_oe, (!tw_b || wr));
    if (stall == 1) begin
      repeat (40) @(negedge clk);
      chk(edges == e0, "R11 tx empty stall", edges - e0, 0);
      tx_en = 1'b1;
    end
    if (stall == 2) begin
      for (int k = 0; k < 5000 && edges - e0 < 16; k++) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(edges - e0 == 16, "R11 rx full stall", edges - e0, 16);
      chk(rx_valid == 1'b1, "R11 rx byte held", rx_valid, 1);
      rx_en = 1'b1;
    end
    send(f_sel(4'h0, 8'hFF));
    send(f_misc(4'h0, id));
    wait_sync(y0);
    chk(sync_n == y0 + 1, "R10 one token", sync_n - y0, 1);
    chk(sync_last == id, "R10 token id", sync_last, id);
    chk(edges - e0 == 16 * n, "R3 edge count", edges - e0, 16 * n);
    chk(mo_n - m0 == n, "R3 byte count", mo_n - m0, n);
    for (int i = 0; i < n; i++) begin
      if (wr) chk(mo_got[(m0 + i) % 1024] == txq[t0 + i], "R3 mosi byte", mo_got[(m0 + i) % 1024], txq[t0 + i]);
      else    chk(mo_got[(m0 + i) % 1024] == 8'h00, "R5 mosi low", mo_got[(m0 + i) % 1024], 0);
    end
    chk(tx_ptr - tp0 == (wr ? n : 0), "R5 tx consumption", tx_ptr - tp0, wr ? n : 0);
    if (rd) begin
      chk(rx_at_sync - r0 == n, "R10 rx done before token", rx_at_sync - r0, n);
      for (int i = 0; i < n; i++)
        chk(rx_got[r0 + i] == slq[s0 + i], "R4 rx byte", rx_got[r0 + i], slq[s0 + i]);
    end else begin
      chk(rx_n == r0, "R4 no rx when read off", rx_n - r0, 0);
    end
    chk(sclk == cpol_b, "R6 idle level", sclk, cpol_b);
    chk(sdo_oe == !tw_b, "R12 oe after transfer", sdo_oe, !tw_b);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t, y0;
    void'($urandom(32'd7741));
    for (int i = 0; i < 1024; i++) slq[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R2 reset state
    chk(cs_n == 8'hFF, "R2 cs_n", cs_n, 8'hFF);
    chk(sclk == 1'b0, "R2 sclk", sclk, 0);
    chk(mosi == 1'b0, "R2 mosi", mosi, 0);
    chk(sdo_oe == 1'b1, "R2 oe", sdo_oe, 1);
    chk(cmd_ready == 1'b1, "R2 ready", cmd_ready, 1);
    chk(rx_valid == 1'b0 && sync_valid == 1'b0, "R2 rx/sync", {rx_valid, sync_valid}, 0);

    // R6 R7 all four modes
    for (int md = 0; md < 4; md++) begin
      set_mode(md[1], md[0], 1'b0, md + 1);
      run_xfer(1'b1, 1'b1, 3, md, 8'(8'h10 + md), 0);
    end
    // R5 read only, R4 write only
    set_mode(1'b0, 1'b1, 1'b0, 2);
    run_xfer(1'b0, 1'b1, 4, 2, 8'h21, 0);
    run_xfer(1'b1, 1'b0, 4, 5, 8'h22, 0);
    // R11 stalls
    run_xfer(1'b1, 1'b1, 2, 1, 8'h23, 1);
    set_mode(1'b1, 1'b0, 1'b0, 1);
    run_xfer(1'b0, 1'b1, 2, 3, 8'h24, 2);
    // R12 three-wire
    set_mode(1'b0, 1'b0, 1'b1, 0);
    chk(sdo_oe == 1'b0, "R12 oe off when idle", sdo_oe, 0);
    run_xfer(1'b1, 1'b0, 2, 4, 8'h25, 0);
    run_xfer(1'b0, 1'b1, 2, 4, 8'h26, 0);
    // R3 full 256-byte count
    set_mode(1'b0, 1'b0, 1'b0, 0);
    run_xfer(1'b1, 1'b1, 256, 7, 8'hFE, 0);
    // R9 pause length
    set_mode(1'b0, 1'b0, 1'b0, 3);
    send_time(f_misc(4'h1, 8'd4), t);
    chk(t == 2 * 5 * 4, "R9 pause cycles", t, 40);
    set_mode(1'b1, 1'b0, 1'b0, 0);
    send_time(f_misc(4'h1, 8'd0), t);
    chk(t == 2, "R9 shortest pause", t, 2);
    chk(sclk == 1'b1, "R9 no sclk toggle in pause", sclk, 1);
    // R8 select hold-off
    set_mode(1'b0, 1'b0, 1'b0, 2);
    send_time(f_sel(4'h5, 8'hFF), t);
    chk(t == 2 * 5 * 3, "R8 select hold-off", t, 30);
    send_time(f_sel(4'h0, 8'hFF), t);
    chk(t == 0, "R8 zero hold-off", t, 0);
    // R13 ignored codes
    y0 = sync_n;
    send_time(16'h5A3C, t);
    chk(t == 0, "R13 unknown opcode", t, 0);
    send(f_misc(4'h7, 8'h11));
    send(f_reg(4'h9, 8'h00));
    send(16'hF1FE);
    repeat (3) @(negedge clk);
    chk(cs_n == 8'hFF, "R13 selects untouched", cs_n, 8'hFF);
    chk(sync_n == y0, "R13 no token", sync_n - y0, 0);
    chk(sclk == 1'b0, "R13 mode untouched", sclk, 0);
    run_xfer(1'b1, 1'b1, 2, 6, 8'h31, 0);  // spacing still div 2
    // random mix
    for (int it = 0; it < 24; it++) begin
      int r;
      r = int'($urandom % 32'd64);
      set_mode(r[0], r[1], 1'b0, int'($urandom % 32'd6));
      run_xfer(r[2], r[3], 1 + int'($urandom % 32'd6), int'($urandom % 32'd8), 8'($urandom), 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule